// File: doc/BRIEF.md
# Start-up EEPROM Presence Probe with Role Latch

This block runs once after reset and decides whether the chip acts as master or slave on its two-wire serial bus for the whole run. It steps a byte-level I2C master engine through a fixed script. First it writes a test byte to a fixed memory location of an EEPROM at device address 0xA0 (the 8-bit write form). It then polls that device until the internal write cycle ends. Last, it reads the location back through a repeated START. The device must acknowledge every byte and the byte read back must match. If both hold, the block latches master role. Any other outcome latches slave role.

The engine is reached over a one-command-at-a-time interface. The block holds `cmd_valid` with an operation and a data byte. The engine completes the command with a one-cycle `rsp_done`, which carries the acknowledge status of a written byte or the byte read. Once the role is latched, `probe_done` rises and the block issues no further commands. The slave-side port enable is released only at that point, and only when the role is slave. Only a reset can start the probe again.

Top module: `eeprom_probe_role`

## Requirements
- R1: Out of reset, `probe_done`, `role_master` and `slave_en` are 0. The first commands are START, WRITE 0xA0, the TEST_ADDR bytes (most significant byte first), WRITE TEST_DATA and STOP. Operation codes on `cmd_op`: 0 START, 1 WRITE, 2 READ, 3 STOP.
- R2: A write byte that is not acknowledged (`rsp_ack`=0) during the write phase is followed by a STOP. After that STOP completes, `probe_done` is 1 with `role_master`=0.
- R3: Each poll attempt is START followed by WRITE 0xA0. A not-acknowledged attempt is followed by STOP. After POLL_MAX not-acknowledged attempts, the probe ends with slave role and starts no further attempt.
- R4: An acknowledged poll is followed, with no STOP, by the TEST_ADDR bytes (most significant byte first), START, WRITE 0xA1, READ and STOP.
- R5: After the final STOP completes, `probe_done` is 1. `role_master` is 1 exactly when the READ returned TEST_DATA.
- R6: Once `probe_done` is 1, it and `role_master` hold until reset and `cmd_valid` stays 0.
- R7: `slave_en` is 0 while `probe_done` is 0. Afterwards it equals the inverse of `role_master`.
- R8: While `cmd_valid` is 1 and `rsp_done` is 0, the next cycle keeps `cmd_valid`, `cmd_op` and `cmd_data` unchanged.
- R9: A not-acknowledged address byte or WRITE 0xA1 during the read-back phase is followed by STOP, then slave role.
- R10: `role_master` is 0 in every cycle before `probe_done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; restarts the probe |
| cmd_valid | output | 1 | A command is presented to the byte engine |
| cmd_op | output | 2 | Command: 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_data | output | 8 | Byte to send for WRITE, otherwise 0 |
| rsp_done | input | 1 | One-cycle completion of the current command |
| rsp_ack | input | 1 | Written byte was acknowledged (valid with rsp_done on WRITE) |
| rsp_data | input | 8 | Byte received (valid with rsp_done on READ) |
| probe_done | output | 1 | Role has been latched |
| role_master | output | 1 | Latched role: 1 master, 0 slave |
| slave_en | output | 1 | Slave-side port may operate |

## Verification
The bench uses ADDR_BYTES=2, TEST_ADDR=16'h1F3C, TEST_DATA=8'h5A and POLL_MAX=4. With two address bytes, a byte-order fault or an index that stops early shows up. With a poll limit of four, both the last acknowledged attempt and full exhaustion can be reached in a few cycles. Engine latency varies at random between commands, so the hold rule on the command outputs is exercised. Random scenarios place the refused byte at random points in all three phases and mix matching and mismatching read-back bytes.

// File: rtl/eeprom_probe_pkg.sv
package eeprom_probe_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [3:0] {
        PH_W_START,
        PH_W_DEV,
        PH_W_ADDR,
        PH_W_DATA,
        PH_W_STOP,
        PH_P_START,
        PH_P_DEV,
        PH_P_STOP,
        PH_R_ADDR,
        PH_R_START,
        PH_R_DEV,
        PH_R_READ,
        PH_R_STOP,
        PH_FAIL_STOP,
        PH_DONE
    } phase_e;

    localparam logic [7:0] DEV_WR = 8'hA0;
    localparam logic [7:0] DEV_RD = 8'hA1;

endpackage

// File: rtl/probe_cmd_map.sv
module probe_cmd_map
    import eeprom_probe_pkg::*;
#(
    parameter int unsigned         ADDR_BYTES = 2,
    parameter int unsigned         IDX_W      = 1,
    parameter logic [8*ADDR_BYTES-1:0] TEST_ADDR = '0,
    parameter logic [7:0]          TEST_DATA  = 8'hA5
) (
    input  phase_e           phase,
    input  logic [IDX_W-1:0] idx,
    output logic             issue,
    output bus_op_e          op,
    output logic [7:0]       data
);

    logic [7:0] addr_byte [ADDR_BYTES];

    // Location bytes go out most significant first
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
        assign addr_byte[g] = TEST_ADDR[8*(ADDR_BYTES-1-g) +: 8];
    end

    always_comb begin
        issue = (phase != PH_DONE);
        op    = OP_START;
        data  = 8'h00;
        unique case (phase)
            PH_W_START, PH_P_START, PH_R_START: op = OP_START;
            PH_W_DEV, PH_P_DEV: begin
                op   = OP_WRITE;
                data = DEV_WR;
            end
            PH_R_DEV: begin
                op   = OP_WRITE;
                data = DEV_RD;
            end
            PH_W_ADDR, PH_R_ADDR: begin
                op   = OP_WRITE;
                data = addr_byte[idx];
            end
            PH_W_DATA: begin
                op   = OP_WRITE;
                data = TEST_DATA;
            end
            PH_R_READ: op = OP_READ;
            PH_W_STOP, PH_P_STOP, PH_R_STOP, PH_FAIL_STOP: op = OP_STOP;
            default: op = OP_START;
        endcase
    end

endmodule

// File: rtl/probe_poll_ctr.sv
module probe_poll_ctr #(
    parameter int unsigned POLL_MAX = 200,
    localparam int unsigned CNT_W   = $clog2(POLL_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bump,
    output logic spent
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (bump && cnt_q != CNT_W'(POLL_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign spent = (cnt_q == CNT_W'(POLL_MAX));

endmodule

// File: rtl/probe_fsm.sv
module probe_fsm
    import eeprom_probe_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 2,
    parameter int unsigned IDX_W      = 1,
    parameter logic [7:0]  TEST_DATA  = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rsp_done,
    input  logic             rsp_ack,
    input  logic [7:0]       rsp_data,
    input  logic             poll_spent,
    output phase_e           phase,
    output logic [IDX_W-1:0] idx,
    output logic             poll_bump,
    output logic             done,
    output logic             master
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ADDR_BYTES - 1);

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] idx;
        logic             verdict;
        logic             done;
        logic             master;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        poll_bump = 1'b0;
        if (rsp_done && st_q.phase != PH_DONE) begin
            unique case (st_q.phase)
                PH_W_START: st_d.phase = PH_W_DEV;
                PH_W_DEV: begin
                    st_d.idx   = '0;
                    st_d.phase = rsp_ack ? PH_W_ADDR : PH_FAIL_STOP;
                end
                PH_W_ADDR: begin
                    if (!rsp_ack)                 st_d.phase = PH_FAIL_STOP;
                    else if (st_q.idx == IDX_LAST) st_d.phase = PH_W_DATA;
                    else                           st_d.idx   = st_q.idx + 1'b1;
                end
                PH_W_DATA:  st_d.phase = rsp_ack ? PH_W_STOP : PH_FAIL_STOP;
                PH_W_STOP:  st_d.phase = PH_P_START;
                PH_P_START: st_d.phase = PH_P_DEV;
                PH_P_DEV: begin
                    st_d.idx = '0;
                    if (rsp_ack) begin
                        st_d.phase = PH_R_ADDR;
                    end else begin
                        poll_bump  = 1'b1;
                        st_d.phase = PH_P_STOP;
                    end
                end
                PH_P_STOP: begin
                    if (poll_spent) begin
                        st_d.phase  = PH_DONE;
                        st_d.done   = 1'b1;
                        st_d.master = 1'b0;
                    end else begin
                        st_d.phase = PH_P_START;
                    end
                end
                PH_R_ADDR: begin
                    if (!rsp_ack)                 st_d.phase = PH_FAIL_STOP;
                    else if (st_q.idx == IDX_LAST) st_d.phase = PH_R_START;
                    else                           st_d.idx   = st_q.idx + 1'b1;
                end
                PH_R_START: st_d.phase = PH_R_DEV;
                PH_R_DEV:   st_d.phase = rsp_ack ? PH_R_READ : PH_FAIL_STOP;
                PH_R_READ: begin
                    st_d.verdict = (rsp_data == TEST_DATA);
                    st_d.phase   = PH_R_STOP;
                end
                PH_R_STOP: begin
                    st_d.phase  = PH_DONE;
                    st_d.done   = 1'b1;
                    st_d.master = st_q.verdict;
                end
                PH_FAIL_STOP: begin
                    st_d.phase  = PH_DONE;
                    st_d.done   = 1'b1;
                    st_d.master = 1'b0;
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_W_START, idx: '0, verdict: 1'b0,
                      done: 1'b0, master: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase  = st_q.phase;
    assign idx    = st_q.idx;
    assign done   = st_q.done;
    assign master = st_q.master;

endmodule

// File: rtl/eeprom_probe_role.sv
module eeprom_probe_role
    import eeprom_probe_pkg::*;
#(
    parameter int unsigned             ADDR_BYTES = 2,
    parameter logic [8*ADDR_BYTES-1:0] TEST_ADDR  = 16'h7FF0,
    parameter logic [7:0]              TEST_DATA  = 8'hA5,
    parameter int unsigned             POLL_MAX   = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic       cmd_valid,
    output logic [1:0] cmd_op,
    output logic [7:0] cmd_data,
    input  logic       rsp_done,
    input  logic       rsp_ack,
    input  logic [7:0] rsp_data,
    output logic       probe_done,
    output logic       role_master,
    output logic       slave_en
);

    localparam int unsigned IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic             poll_bump;
    logic             poll_spent;
    bus_op_e          op;
    logic             done;
    logic             master;

    probe_fsm #(
        .ADDR_BYTES (ADDR_BYTES),
        .IDX_W      (IDX_W),
        .TEST_DATA  (TEST_DATA)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rsp_done   (rsp_done),
        .rsp_ack    (rsp_ack),
        .rsp_data   (rsp_data),
        .poll_spent (poll_spent),
        .phase      (phase),
        .idx        (idx),
        .poll_bump  (poll_bump),
        .done       (done),
        .master     (master)
    );

    probe_poll_ctr #(
        .POLL_MAX (POLL_MAX)
    ) i_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (poll_bump),
        .spent (poll_spent)
    );

    probe_cmd_map #(
        .ADDR_BYTES (ADDR_BYTES),
        .IDX_W      (IDX_W),
        .TEST_ADDR  (TEST_ADDR),
        .TEST_DATA  (TEST_DATA)
    ) i_map (
        .phase (phase),
        .idx   (idx),
        .issue (cmd_valid),
        .op    (op),
        .data  (cmd_data)
    );

    assign cmd_op      = op;
    assign probe_done  = done;
    assign role_master = master;
    assign slave_en    = done && !master;

endmodule

// File: rtl/eeprom_probe_role_chk.sv
module eeprom_probe_role_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic [7:0] cmd_data,
    input logic       rsp_done,
    input logic       rsp_ack,
    input logic [7:0] rsp_data,
    input logic       probe_done,
    input logic       role_master,
    input logic       slave_en
);

    assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !rsp_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_data)));

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        probe_done |=> (probe_done && $stable(role_master)));

    assert_quiet_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        probe_done |-> !cmd_valid);

    assert_no_early_role_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !probe_done |-> (!role_master && !slave_en));

    assert_slave_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        probe_done |-> (slave_en == !role_master));

    // R2, R3, R9: every refused byte is followed by a STOP
    assert_nack_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && rsp_done && cmd_op == 2'd1 && !rsp_ack) |=> (cmd_valid && cmd_op == 2'd3));

    // R5: master role only rises right after a completed STOP
    assert_master_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && cmd_valid && cmd_op != 2'd3) |=> !$rose(role_master));

endmodule

bind eeprom_probe_role eeprom_probe_role_chk i_chk (.*);

// File: tb/test_eeprom_probe_role.sv
module test_eeprom_probe_role;

    localparam int          CLK_PERIOD = 10;
    localparam int          AB         = 2;
    localparam logic [15:0] TA         = 16'h1F3C;
    localparam logic [7:0]  TD         = 8'h5A;
    localparam int          PMAX       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid;
    logic [1:0] cmd_op;
    logic [7:0] cmd_data;
    logic       rsp_done = 1'b0;
    logic       rsp_ack = 1'b0;
    logic [7:0] rsp_data = 8'hFF;
    logic       probe_done;
    logic       role_master;
    logic       slave_en;

    int n_chk = 0;
    int n_bad = 0;
    bit hung = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_probe_role #(
        .ADDR_BYTES (AB),
        .TEST_ADDR  (TA),
        .TEST_DATA  (TD),
        .POLL_MAX   (PMAX)
    ) i_eeprom_probe_role (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_data    (cmd_data),
        .rsp_done    (rsp_done),
        .rsp_ack     (rsp_ack),
        .rsp_data    (rsp_data),
        .probe_done  (probe_done),
        .role_master (role_master),
        .slave_en    (slave_en)
    );

    function automatic logic [7:0] addr_byte(input int i);
        return TA[8*(AB-1-i) +: 8];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Acts as the byte engine for one expected command
    task automatic serve(input logic [1:0] op, input logic [7:0] data,
                         input logic ack, input logic [7:0] rdata, input string req);
        int n = 0;
        logic [1:0] op0;
        logic [7:0] d0;
        if (hung) return;
        while (!cmd_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        if (!cmd_valid) begin
            chk(0, req, "no command issued", 0, 1);
            hung = 1;
            return;
        end
        chk(cmd_op == op, req, "command op", cmd_op, op);
        if (op == 2'd1) chk(cmd_data == data, req, "write byte", cmd_data, data);
        chk(!role_master, "R10", "role before done", role_master, 0);
        op0 = cmd_op;
        d0  = cmd_data;
        for (int k = 0; k < int'($urandom_range(0, 3)); k++) begin
            @(negedge clk);
            chk(cmd_valid && cmd_op == op0 && cmd_data == d0, "R8", "command held",
                {cmd_valid, cmd_op, cmd_data}, {1'b1, op0, d0});
        end
        rsp_done = 1'b1;
        rsp_ack  = ack;
        rsp_data = rdata;
        @(negedge clk);
        rsp_done = 1'b0;
        rsp_ack  = 1'b0;
        rsp_data = 8'hFF;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!probe_done && !role_master && !slave_en, "R1", "reset outputs",
            {probe_done, role_master, slave_en}, 0);
        rst_n = 1'b1;
    endtask

    task automatic expect_end(input bit exp_m, input string req);
        if (hung) return;
        chk(probe_done == 1'b1, req, "done", probe_done, 1);
        chk(role_master == exp_m, req, "role", role_master, exp_m);
        chk(slave_en == !exp_m, "R7", "slave enable", slave_en, !exp_m);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(!cmd_valid && probe_done && role_master == exp_m, "R6", "latched and quiet",
                {cmd_valid, probe_done, role_master}, {1'b0, 1'b1, exp_m});
        end
    endtask

    // wfail: refused byte in write phase (0 device, 1..AB address, AB+1 data), -1 none
    // pnacks: refused poll attempts before acknowledge
    // rfail: refused byte in read phase (0..AB-1 address, AB device), -1 none
    task automatic probe(input int wfail, input int pnacks, input int rfail,
                         input logic [7:0] rdata);
        do_reset();
        serve(2'd0, 8'h00, 0, 8'hFF, "R1");
        for (int b = 0; b <= AB + 1; b++) begin
            logic [7:0] v;
            v = (b == 0) ? 8'hA0 : (b <= AB) ? addr_byte(b - 1) : TD;
            serve(2'd1, v, wfail != b, 8'hFF, "R1");
            if (wfail == b) begin
                serve(2'd3, 8'h00, 0, 8'hFF, "R2");
                expect_end(0, "R2");
                return;
            end
        end
        serve(2'd3, 8'h00, 0, 8'hFF, "R1");
        for (int k = 0; ; k++) begin
            serve(2'd0, 8'h00, 0, 8'hFF, "R3");
            if (k < pnacks) begin
                serve(2'd1, 8'hA0, 0, 8'hFF, "R3");
                serve(2'd3, 8'h00, 0, 8'hFF, "R3");
                if (k + 1 == PMAX) begin
                    expect_end(0, "R3");
                    return;
                end
            end else begin
                serve(2'd1, 8'hA0, 1, 8'hFF, "R3");
                break;
            end
            if (hung) return;
        end
        for (int b = 0; b < AB; b++) begin
            serve(2'd1, addr_byte(b), rfail != b, 8'hFF, "R4");
            if (rfail == b) begin
                serve(2'd3, 8'h00, 0, 8'hFF, "R9");
                expect_end(0, "R9");
                return;
            end
        end
        serve(2'd0, 8'h00, 0, 8'hFF, "R4");
        serve(2'd1, 8'hA1, rfail != AB, 8'hFF, "R4");
        if (rfail == AB) begin
            serve(2'd3, 8'h00, 0, 8'hFF, "R9");
            expect_end(0, "R9");
            return;
        end
        serve(2'd2, 8'h00, 0, rdata, "R4");
        serve(2'd3, 8'h00, 0, 8'hFF, "R4");
        expect_end(rdata == TD, "R5");
    endtask

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        // Directed corners
        probe(-1, 0, -1, TD);            // R5 present, master
        probe(-1, 0, -1, TD ^ 8'h01);    // R5 mismatch, slave
        probe(0, 0, -1, TD);             // R2 device refused
        probe(AB + 1, 0, -1, TD);        // R2 data refused
        probe(-1, PMAX, -1, TD);         // R3 poll exhausted
        probe(-1, PMAX - 1, -1, TD);     // R3 last attempt acknowledged
        probe(-1, 1, AB, TD);            // R9 read device refused
        probe(-1, 0, 0, TD);             // R9 address refused
        // Random mix
        for (int s = 0; s < 24 && !hung; s++) begin
            int mode;
            mode = int'($urandom_range(0, 3));
            case (mode)
                0: probe(int'($urandom_range(0, AB + 1)), 0, -1, TD);
                1: probe(-1, int'($urandom_range(0, PMAX)), -1, TD);
                2: probe(-1, int'($urandom_range(0, 2)), int'($urandom_range(0, AB)), TD);
                default: probe(-1, int'($urandom_range(0, PMAX - 1)), -1,
                               ($urandom_range(0, 1) == 0) ? TD : 8'($urandom));
            endcase
        end
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual expired expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule